// File: doc/BRIEF.md
# Dual-Style "Zero Then One" Serial Detector

This block watches a serial bit stream, one bit per clock when the qualifier is high, and flags every place where a 0 is immediately followed by a 1. One state register feeds two detect outputs. The fast output reacts in the same cycle as the completing 1, because it decodes the current state together with the incoming bit. The slow output decodes the registered state alone, so it rises one cycle later and is free of any combinational path from the serial input.

The machine has three live states: idle, zero-seen and zero-one-seen. A second 1 in a row after a match sends it back to idle rather than keeping it in the matched state. Cycles without a qualified bit leave the state untouched. The one spare state code returns to idle on the next qualified bit.

Top module: `seqdet_dual`

## Requirements
- R1: While `rst_n` is low, both `det_fast` and `det_slow` are 0, and the machine is in idle once `rst_n` is released.
- R2: From idle, a qualified 1 keeps the machine in idle and a qualified 0 moves it to zero-seen.
- R3: From zero-seen, a qualified 0 keeps it in zero-seen and a qualified 1 moves it to zero-one-seen.
- R4: From zero-one-seen, a qualified 0 moves it to zero-seen and a qualified 1 moves it to idle.
- R5: `det_fast` is 1 exactly when `bit_vld` is 1, `bit_in` is 1 and the machine is in zero-seen, and 0 otherwise.
- R6: `det_slow` is 1 exactly while the machine is in zero-one-seen, so it follows a qualified `det_fast` pulse by one cycle.
- R7: With `bit_vld` at 0, the state holds and `det_fast` is 0 whatever `bit_in` is.
- R8: After reset, the qualified stream 0,1,0,1,1,0,1 produces `det_fast` values 0,1,0,1,0,0,1 in those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Qualifier; `bit_in` counts only while high |
| det_fast | output | 1 | Same-cycle detect, decoded from state and input |
| det_slow | output | 1 | Registered detect, decoded from state only |

## Verification
A run of three ones from idle, a run of zeros closed by a single one, and a match followed by a second one separate the three states' self-loops from their exits, because each state answers 0 and 1 differently on the two outputs. The interleaved stream 0,1,0,1,1,0,1 tells the overlapping re-arm after a match apart from the reset-to-idle on a double one. Cycles with the qualifier low and the data bit high, taken in zero-seen and in zero-one-seen, show that the state holds and the fast output stays quiet. A reset taken in the middle of a match confirms that both outputs drop and that detection starts again from idle.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;
  localparam int unsigned ST_W = 2;

  // Binary codes; the spare code is never entered from a live state.
  typedef enum logic [ST_W-1:0] {
    ST_IDLE  = 2'b00,
    ST_GOT0  = 2'b01,
    ST_GOT01 = 2'b10,
    ST_SPARE = 2'b11
  } seq_st_e;
endpackage

// File: rtl/seqdet_next.sv
module seqdet_next
  import seqdet_pkg::*;
(
  input  seq_st_e cur_st,
  input  logic    bit_in,
  input  logic    bit_vld,
  output seq_st_e nxt_st,
  output logic    hit
);
  // Transition table; applied by the register only on qualified bits.
  always_comb begin
    nxt_st = ST_IDLE;
    case (cur_st)
      ST_IDLE:  nxt_st = bit_in ? ST_IDLE  : ST_GOT0;
      ST_GOT0:  nxt_st = bit_in ? ST_GOT01 : ST_GOT0;
      ST_GOT01: nxt_st = bit_in ? ST_IDLE  : ST_GOT0;
      default:  nxt_st = ST_IDLE;
    endcase
  end

  // Same-cycle detect: completing 1 arriving while a 0 is held.
  always_comb begin
    hit = bit_vld & bit_in & (cur_st == ST_GOT0);
  end
endmodule

// File: rtl/seqdet_slow_dec.sv
module seqdet_slow_dec
  import seqdet_pkg::*;
(
  input  seq_st_e cur_st,
  output logic    matched
);
  always_comb begin
    matched = (cur_st == ST_GOT01);
  end
endmodule

// File: rtl/seqdet_dual.sv
module seqdet_dual
  import seqdet_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_in,
  input  logic bit_vld,
  output logic det_fast,
  output logic det_slow
);
  seq_st_e state_q;
  seq_st_e state_d;
  logic    hit_w;
  logic    match_w;

  seqdet_next u_next (
    .cur_st  (state_q),
    .bit_in  (bit_in),
    .bit_vld (bit_vld),
    .nxt_st  (state_d),
    .hit     (hit_w)
  );

  seqdet_slow_dec u_dec (
    .cur_st  (state_q),
    .matched (match_w)
  );

  // State register with explicit clock enable on the qualifier.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (bit_vld) begin
      state_q <= state_d;
    end
  end

  assign det_fast = hit_w;
  assign det_slow = match_w;
endmodule

// File: rtl/seqdet_chk.sv
module seqdet_chk
  import seqdet_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    bit_in,
  input logic    bit_vld,
  input logic    det_fast,
  input logic    det_slow,
  input seq_st_e state_q
);
  // R1: outputs quiet while reset is held
  always @(negedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!det_fast && !det_slow)
        else $error("reset outputs not quiet");
    end
  end

  p_idle_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && bit_vld && bit_in) |=> (state_q == ST_IDLE));

  p_match_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (det_slow && bit_vld) |=> !det_slow);

  p_fast_needs_vld_r5: assert property (@(posedge clk) disable iff (!rst_n)
    det_fast |-> (bit_vld && bit_in));

  p_slow_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    det_fast |=> det_slow);

  p_slow_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_slow) |-> $past(det_fast));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> $stable(state_q));
endmodule

bind seqdet_dual seqdet_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_in   (bit_in),
  .bit_vld  (bit_vld),
  .det_fast (det_fast),
  .det_slow (det_slow),
  .state_q  (state_q)
);

// File: tb/sim_seqdet_dual.sv
`timescale 1ns/1ps
module sim_seqdet_dual;
  logic clk = 1'b0;
  logic rst_n;
  logic bit_in;
  logic bit_vld;
  logic det_fast;
  logic det_slow;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  int ms     = 0;   // bench model: 0 idle, 1 zero-seen, 2 zero-one-seen

  typedef struct {
    logic  f;
    logic  s;
    string tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;   // 50 MHz

  seqdet_dual u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_in   (bit_in),
    .bit_vld  (bit_vld),
    .det_fast (det_fast),
    .det_slow (det_slow)
  );

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Driver: apply one cycle of input and push what the outputs must show.
  task automatic drive(input logic v, input logic b, input string tag);
    exp_t e;
    @(negedge clk);
    bit_vld = v;
    bit_in  = b;
    e.f   = v && b && (ms == 1);
    e.s   = (ms == 2);
    e.tag = tag;
    q.push_back(e);
    if (v) begin
      case (ms)
        0:       ms = b ? 0 : 1;
        1:       ms = b ? 2 : 1;
        default: ms = b ? 0 : 1;
      endcase
    end
  endtask

  // Monitor: compare mid low phase, after inputs have settled.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(det_fast, e.f, e.tag, "det_fast");
        check(det_slow, e.s, e.tag, "det_slow");
      end
    end
  end

  task automatic drain();
    @(negedge clk);
    #8;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bit_in = 1'b1; bit_vld = 1'b1;
    repeat (3) @(negedge clk);
    #5;
    check(det_fast, 1'b0, "R1", "det_fast in reset");
    check(det_slow, 1'b0, "R1", "det_slow in reset");
    @(negedge clk);
    bit_vld = 1'b0; rst_n = 1'b1; ms = 0;

    // R8 stream from idle
    drive(1, 0, "R8"); drive(1, 1, "R8"); drive(1, 0, "R8"); drive(1, 1, "R8");
    drive(1, 1, "R8"); drive(1, 0, "R8"); drive(1, 1, "R8");
    // R4 exit on one -> idle, then R2 stay on ones
    drive(1, 1, "R4"); drive(1, 1, "R2"); drive(1, 1, "R2"); drive(1, 1, "R2");
    // R2 exit on zero, R3 stay on zeros, R3 exit on one
    drive(1, 0, "R2"); drive(1, 0, "R3"); drive(1, 0, "R3"); drive(1, 1, "R3/R5");
    // R6 slow flag present, R4 exit on zero, then re-match
    drive(1, 0, "R4/R6"); drive(1, 1, "R5"); drive(1, 0, "R6");
    // R7 qualifier low in zero-seen with data high
    drive(0, 1, "R7"); drive(0, 1, "R7"); drive(0, 0, "R7"); drive(1, 1, "R7/R5");
    // R7 qualifier low in zero-one-seen: slow flag holds
    drive(0, 1, "R7/R6"); drive(0, 0, "R7/R6"); drive(1, 1, "R6");
    drive(1, 0, "R5"); drive(1, 1, "R5");
    drain();

    // R1 reset in the middle of a match
    rst_n = 1'b0;
    #1;
    check(det_fast, 1'b0, "R1", "det_fast mid reset");
    check(det_slow, 1'b0, "R1", "det_slow mid reset");
    ms = 0;
    @(negedge clk);
    bit_vld = 1'b0;
    rst_n = 1'b1;
    drive(1, 1, "R1"); drive(1, 0, "R1"); drive(1, 1, "R1/R5"); drive(0, 0, "R6");
    drain();
    drain();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule